// File: doc/BRIEF.md
# Link Bring-Up and Speed Upgrade Controller

This block runs the start-up sequence of a serial link whose training state machine lives outside it. On a start request it programs the link's maximum-speed field to the first generation and only then enables training. This keeps devices that sit behind a switch from being missed when the link comes up. It then waits, within a bounded window, for the link-up bit in a PHY debug status word.

When the second generation is permitted, the controller raises the maximum-speed field to 2 after the first link-up and issues a one-cycle directed-speed-change request. On variants whose hardware clears the speed-change bit when the change ends, it waits for that bit to read 0, within its own window. On variants that leave the bit set when the speed does not change, it skips this wait. In both cases it waits for link-up once more before declaring success.

On success it reports the current speed, taken from the link status word. On any expired window it forces two receiver override bits of the PHY for a fixed hold time, then reports failure. The results (a done pulse, a fail flag and a 4-bit speed) stay frozen while the controller is busy.

Top module: `link_upgrade_ctrl`

## Requirements
- R1: After `start_i` is accepted, `max_speed_o` equals 1 in the cycle in which `train_en_o` rises, whatever the value of `allow_gen2_i`.
- R2: With `allow_gen2_i`=1, after the first link-up `max_speed_o` becomes 2 before `dsc_set_o` pulses high for exactly one cycle. With `allow_gen2_i`=0, `dsc_set_o` never pulses and the run completes after the first link-up.
- R3: With `wait_dsc_i`=1, the controller advances past the speed change only once `dsc_busy_i` reads 0. If `dsc_busy_i` is still 1 for DSC_TMO cycles after the `dsc_set_o` cycle, the run fails, and the override rises DSC_TMO+1 cycles after that pulse.
- R4: With `wait_dsc_i`=0, `dsc_busy_i` is ignored: a run whose `dsc_busy_i` stays 1 forever still succeeds once the link is up again.
- R5: Link-up is bit 4 of `phy_dbg_i`. After a speed change the link must be seen up a second time before success is reported.
- R6: Each link-up wait lasts LINK_TMO cycles. Link-up first visible at the LINK_TMO-th rising edge after `train_en_o` rises still succeeds; one cycle later it fails, and the override rises LINK_TMO cycles after `train_en_o` rises.
- R7: On failure `phy_rx_ovrd_o` equals 16'h0028 (bit 5 receiver data enable, bit 3 receiver PLL enable) for exactly PHY_HOLD cycles and is 0 otherwise. When it clears, `done_o`=1, `fail_o`=1 and `speed_o`=0.
- R8: On success `fail_o`=0 and `speed_o` holds bits 19:16 of `link_stat_i`, sampled at completion.
- R9: `done_o` is a one-cycle pulse that occurs while `busy_o`=0. While busy, `done_o` stays 0 and `fail_o` and `speed_o` keep their values.
- R10: `start_i` is ignored while `busy_o`=1: it gives no second speed-change request, no second done pulse and no restart.
- R11: After reset `busy_o`, `done_o`, `fail_o`, `train_en_o` and `dsc_set_o` are 0, `speed_o` and `phy_rx_ovrd_o` are 0, and `max_speed_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a bring-up run (accepted only when idle) |
| allow_gen2_i | input | 1 | Second generation permitted; hold stable while busy |
| wait_dsc_i | input | 1 | Variant clears the speed-change bit when done; hold stable while busy |
| phy_dbg_i | input | 32 | PHY debug status word, link-up at bit 4 |
| link_stat_i | input | 32 | Link status word, current speed at bits 19:16 |
| dsc_busy_i | input | 1 | Read-back of the directed-speed-change bit |
| max_speed_o | output | 4 | Maximum link speed field driven to the link core |
| train_en_o | output | 1 | Enable for the link training state machine |
| dsc_set_o | output | 1 | One-cycle request to set the directed-speed-change bit |
| phy_rx_ovrd_o | output | 16 | PHY receiver override word |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Last run failed |
| speed_o | output | 4 | Speed reported by the last run |

## Verification
The hardest case to reach is the variant that never clears the speed-change bit when the speed stays the same. In that case `dsc_busy_i` stays high forever, and only the variant input decides between success and a timeout. The bench's model of the training machine sets its busy bit on each `dsc_set_o` pulse and can be told never to release it. The same stuck stimulus is then run once with `wait_dsc_i`=0, where it must succeed, and once with `wait_dsc_i`=1, where it must fail at an exact cycle count. The link-up window boundary is hit by placing link-up at the last admitted cycle and one cycle past it, both counted from the observed rise of `train_en_o`.

// File: rtl/lup_pkg.sv
package lup_pkg;

  localparam int STATUS_W      = 32;
  localparam int SPEED_W       = 4;
  localparam int OVRD_W        = 16;
  localparam int LINK_UP_BIT   = 4;
  localparam int SPEED_LSB     = 16;
  localparam int RX_DATA_EN_BIT = 5;
  localparam int RX_PLL_EN_BIT  = 3;

  localparam logic [SPEED_W-1:0] SPEED_GEN1 = 4'd1;
  localparam logic [SPEED_W-1:0] SPEED_GEN2 = 4'd2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT_UP1,
    ST_RAISE,
    ST_KICK,
    ST_WAIT_DSC,
    ST_WAIT_UP2,
    ST_REPORT,
    ST_RX_HOLD
  } lup_state_e;

  // link-up flag inside the PHY debug status word
  function automatic logic link_up_of(input logic [STATUS_W-1:0] dbg);
    return dbg[LINK_UP_BIT];
  endfunction

  // current speed field inside the link status word
  function automatic logic [SPEED_W-1:0] speed_of(input logic [STATUS_W-1:0] stat);
    return stat[SPEED_LSB +: SPEED_W];
  endfunction

  // receiver override word: both enables forced while active
  function automatic logic [OVRD_W-1:0] rx_ovrd_word(input logic active);
    logic [OVRD_W-1:0] w;
    w = '0;
    w[RX_DATA_EN_BIT] = active;
    w[RX_PLL_EN_BIT]  = active;
    return w;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/lup_timer.sv
module lup_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  // window of exactly limit_i cycles after a clear
  assign expired_o = (cnt_q == (limit_i - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (!expired_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/lup_status_decode.sv
module lup_status_decode
  import lup_pkg::*;
(
  input  logic [STATUS_W-1:0] dbg_i,
  input  logic [STATUS_W-1:0] stat_i,
  output logic                link_up_o,
  output logic [SPEED_W-1:0]  speed_o
);

  assign link_up_o = link_up_of(dbg_i);
  assign speed_o   = speed_of(stat_i);

  logic unused_status_bits;
  assign unused_status_bits = ^{dbg_i[STATUS_W-1:LINK_UP_BIT+1], dbg_i[LINK_UP_BIT-1:0],
                                stat_i[STATUS_W-1:SPEED_LSB+SPEED_W], stat_i[SPEED_LSB-1:0]};

endmodule

// File: rtl/lup_rx_reset.sv
module lup_rx_reset
  import lup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  output logic [OVRD_W-1:0] ovrd_o
);

  logic active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (set_i) begin
      active_q <= 1'b1;
    end else if (clr_i) begin
      active_q <= 1'b0;
    end
  end

  assign ovrd_o = rx_ovrd_word(active_q);

endmodule

// File: rtl/lup_seq.sv
module lup_seq
  import lup_pkg::*;
#(
  parameter int LINK_TMO = 16,
  parameter int DSC_TMO  = 16,
  parameter int PHY_HOLD = 16,
  parameter int CW       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               allow_gen2_i,
  input  logic               wait_dsc_i,
  input  logic               link_up_i,
  input  logic               dsc_busy_i,
  input  logic [SPEED_W-1:0] cur_speed_i,
  input  logic               tmr_expired_i,
  output logic               tmr_clr_o,
  output logic [CW-1:0]      tmr_limit_o,
  output logic               hold_set_o,
  output logic               hold_clr_o,
  output logic [SPEED_W-1:0] max_speed_o,
  output logic               train_en_o,
  output logic               dsc_set_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               fail_o,
  output logic [SPEED_W-1:0] speed_o,
  output logic               ev_timeout_o,
  output logic               ev_link_seen_o
);

  localparam logic [CW-1:0] LIM_LINK = CW'(LINK_TMO);
  localparam logic [CW-1:0] LIM_DSC  = CW'(DSC_TMO);
  localparam logic [CW-1:0] LIM_HOLD = CW'(PHY_HOLD);

  lup_state_e st_q, st_d;

  always_comb begin
    st_d           = st_q;
    tmr_clr_o      = 1'b0;
    hold_set_o     = 1'b0;
    hold_clr_o     = 1'b0;
    ev_timeout_o   = 1'b0;
    ev_link_seen_o = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) st_d = ST_ARM;
      ST_ARM: begin
        tmr_clr_o = 1'b1;
        st_d      = ST_WAIT_UP1;
      end
      ST_WAIT_UP1: begin
        if (link_up_i) begin
          ev_link_seen_o = 1'b1;
          st_d = allow_gen2_i ? ST_RAISE : ST_REPORT;
        end else if (tmr_expired_i) begin
          ev_timeout_o = 1'b1;
          tmr_clr_o    = 1'b1;
          hold_set_o   = 1'b1;
          st_d         = ST_RX_HOLD;
        end
      end
      ST_RAISE: st_d = ST_KICK;
      ST_KICK: begin
        tmr_clr_o = 1'b1;
        st_d      = wait_dsc_i ? ST_WAIT_DSC : ST_WAIT_UP2;
      end
      ST_WAIT_DSC: begin
        if (!dsc_busy_i) begin
          tmr_clr_o = 1'b1;
          st_d      = ST_WAIT_UP2;
        end else if (tmr_expired_i) begin
          ev_timeout_o = 1'b1;
          tmr_clr_o    = 1'b1;
          hold_set_o   = 1'b1;
          st_d         = ST_RX_HOLD;
        end
      end
      ST_WAIT_UP2: begin
        if (link_up_i) begin
          ev_link_seen_o = 1'b1;
          st_d = ST_REPORT;
        end else if (tmr_expired_i) begin
          ev_timeout_o = 1'b1;
          tmr_clr_o    = 1'b1;
          hold_set_o   = 1'b1;
          st_d         = ST_RX_HOLD;
        end
      end
      ST_REPORT: st_d = ST_IDLE;
      ST_RX_HOLD: begin
        if (tmr_expired_i) begin
          hold_clr_o = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (st_q)
      ST_WAIT_DSC: tmr_limit_o = LIM_DSC;
      ST_RX_HOLD:  tmr_limit_o = LIM_HOLD;
      default:     tmr_limit_o = LIM_LINK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      max_speed_o <= SPEED_GEN1;
      train_en_o  <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      speed_o     <= '0;
    end else begin
      st_q   <= st_d;
      done_o <= 1'b0;
      if (st_q == ST_IDLE && start_i) begin
        max_speed_o <= SPEED_GEN1;
        train_en_o  <= 1'b0;
      end
      if (st_q == ST_ARM)   train_en_o  <= 1'b1;
      if (st_q == ST_RAISE) max_speed_o <= SPEED_GEN2;
      if (st_q == ST_REPORT) begin
        done_o  <= 1'b1;
        fail_o  <= 1'b0;
        speed_o <= cur_speed_i;
      end
      if (hold_clr_o) begin
        done_o  <= 1'b1;
        fail_o  <= 1'b1;
        speed_o <= '0;
      end
    end
  end

  assign dsc_set_o = (st_q == ST_KICK);
  assign busy_o    = (st_q != ST_IDLE);

endmodule

// File: rtl/link_upgrade_ctrl.sv
module link_upgrade_ctrl
  import lup_pkg::*;
#(
  parameter int LINK_TMO = 12_500_000,
  parameter int DSC_TMO  = 125_000_000,
  parameter int PHY_HOLD = 250_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        allow_gen2_i,
  input  logic        wait_dsc_i,
  input  logic [31:0] phy_dbg_i,
  input  logic [31:0] link_stat_i,
  input  logic        dsc_busy_i,
  output logic [3:0]  max_speed_o,
  output logic        train_en_o,
  output logic        dsc_set_o,
  output logic [15:0] phy_rx_ovrd_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        fail_o,
  output logic [3:0]  speed_o
);

  localparam int MAX_T = max3(LINK_TMO, DSC_TMO, PHY_HOLD);
  localparam int CW    = $clog2(MAX_T + 1);

  logic               link_up;
  logic [SPEED_W-1:0] cur_speed;
  logic               tmr_clr;
  logic [CW-1:0]      tmr_limit;
  logic               tmr_expired;
  logic               hold_set;
  logic               hold_clr;
  logic               ev_timeout;
  logic               ev_link_seen;

  lup_status_decode u_decode (
    .dbg_i     (phy_dbg_i),
    .stat_i    (link_stat_i),
    .link_up_o (link_up),
    .speed_o   (cur_speed)
  );

  lup_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .limit_i   (tmr_limit),
    .expired_o (tmr_expired)
  );

  lup_seq #(
    .LINK_TMO (LINK_TMO),
    .DSC_TMO  (DSC_TMO),
    .PHY_HOLD (PHY_HOLD),
    .CW       (CW)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .allow_gen2_i   (allow_gen2_i),
    .wait_dsc_i     (wait_dsc_i),
    .link_up_i      (link_up),
    .dsc_busy_i     (dsc_busy_i),
    .cur_speed_i    (cur_speed),
    .tmr_expired_i  (tmr_expired),
    .tmr_clr_o      (tmr_clr),
    .tmr_limit_o    (tmr_limit),
    .hold_set_o     (hold_set),
    .hold_clr_o     (hold_clr),
    .max_speed_o    (max_speed_o),
    .train_en_o     (train_en_o),
    .dsc_set_o      (dsc_set_o),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .fail_o         (fail_o),
    .speed_o        (speed_o),
    .ev_timeout_o   (ev_timeout),
    .ev_link_seen_o (ev_link_seen)
  );

  lup_rx_reset u_rx_reset (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hold_set),
    .clr_i  (hold_clr),
    .ovrd_o (phy_rx_ovrd_o)
  );

endmodule

// File: rtl/link_upgrade_ctrl_chk.sv
module link_upgrade_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        allow_gen2_i,
  input logic [31:0] link_stat_i,
  input logic [3:0]  max_speed_o,
  input logic        train_en_o,
  input logic        dsc_set_o,
  input logic [15:0] phy_rx_ovrd_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        fail_o,
  input logic [3:0]  speed_o,
  input logic        ev_timeout,
  input logic        ev_link_seen
);

  assert_gen1_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en_o) |-> max_speed_o == 4'd1);

  assert_raise_before_kick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_set_o |-> (max_speed_o == 4'd2) && allow_gen2_i);

  assert_kick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_set_o |=> !dsc_set_o);

  assert_timeout_to_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> phy_rx_ovrd_o == 16'h0028);

  assert_link_not_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_link_seen |-> !ev_timeout);

  assert_ovrd_values_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rx_ovrd_o == 16'h0000) || (phy_rx_ovrd_o == 16'h0028));

  assert_hold_end_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_rx_ovrd_o[5]) |-> done_o && fail_o && (speed_o == 4'd0));

  assert_success_speed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fail_o) |-> speed_o == $past(link_stat_i[19:16]));

  assert_quiet_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(fail_o) && $stable(speed_o) && !done_o));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind link_upgrade_ctrl link_upgrade_ctrl_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .allow_gen2_i  (allow_gen2_i),
  .link_stat_i   (link_stat_i),
  .max_speed_o   (max_speed_o),
  .train_en_o    (train_en_o),
  .dsc_set_o     (dsc_set_o),
  .phy_rx_ovrd_o (phy_rx_ovrd_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .fail_o        (fail_o),
  .speed_o       (speed_o),
  .ev_timeout    (ev_timeout),
  .ev_link_seen  (ev_link_seen)
);

// File: tb/link_upgrade_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_upgrade_ctrl_tb_top;

  localparam int LINK_TMO = 40;
  localparam int DSC_TMO  = 60;
  localparam int PHY_HOLD = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        allow_gen2_i = 1'b0;
  logic        wait_dsc_i = 1'b0;
  logic [31:0] phy_dbg_i;
  logic [31:0] link_stat_i;
  logic        dsc_busy_i;
  logic [3:0]  max_speed_o;
  logic        train_en_o;
  logic        dsc_set_o;
  logic [15:0] phy_rx_ovrd_o;
  logic        busy_o;
  logic        done_o;
  logic        fail_o;
  logic [3:0]  speed_o;

  always #4 clk = ~clk;

  link_upgrade_ctrl #(
    .LINK_TMO (LINK_TMO),
    .DSC_TMO  (DSC_TMO),
    .PHY_HOLD (PHY_HOLD)
  ) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .allow_gen2_i  (allow_gen2_i),
    .wait_dsc_i    (wait_dsc_i),
    .phy_dbg_i     (phy_dbg_i),
    .link_stat_i   (link_stat_i),
    .dsc_busy_i    (dsc_busy_i),
    .max_speed_o   (max_speed_o),
    .train_en_o    (train_en_o),
    .dsc_set_o     (dsc_set_o),
    .phy_rx_ovrd_o (phy_rx_ovrd_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .fail_o        (fail_o),
    .speed_o       (speed_o)
  );

  // training machine model knobs (0 = never)
  int d1, d2, dclr;
  logic [3:0] sp1, sp2;
  // model state
  logic lnk_up, busy_m;
  logic [3:0] cur_sp;
  int ph, mcnt, cyc;
  // monitors
  int dsc_pulses, done_pulses, ovrd_cycles, bad_ovrd, quiet_viol;
  int train_cyc, kick_cyc, ovrd_first;
  logic [3:0] max_at_train, max_at_dsc;
  logic prev_train, prev_busy, prev_fail;
  logic [3:0] prev_speed;
  int total = 0, fails = 0;

  assign phy_dbg_i   = 32'hE3C0_0A0F | (32'(lnk_up) << 4);
  assign link_stat_i = {12'hA5C, cur_sp, 16'h5F3E};
  assign dsc_busy_i  = busy_m;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      lnk_up = 0; busy_m = 0; ph = 1; mcnt = 0; cur_sp = 0;
      prev_train = 0; prev_busy = 0; prev_fail = 0; prev_speed = 0;
    end else begin
      if (dsc_set_o) begin
        busy_m = 1; lnk_up = 0; ph = 2; mcnt = 0;
        dsc_pulses++; max_at_dsc = max_speed_o; kick_cyc = cyc;
      end else if (!train_en_o) begin
        lnk_up = 0; ph = 1; mcnt = 0;
      end else begin
        mcnt++;
        if (ph == 1 && d1 != 0 && mcnt == d1) begin lnk_up = 1; cur_sp = sp1; end
        if (ph == 2) begin
          if (dclr != 0 && mcnt == dclr) busy_m = 0;
          if (d2 != 0 && mcnt == d2) begin lnk_up = 1; cur_sp = sp2; end
        end
      end
      if (train_en_o && !prev_train) begin max_at_train = max_speed_o; train_cyc = cyc; end
      if (phy_rx_ovrd_o == 16'h0028) begin
        if (ovrd_cycles == 0) ovrd_first = cyc;
        ovrd_cycles++;
      end else if (phy_rx_ovrd_o != 16'h0000) bad_ovrd++;
      if (done_o) done_pulses++;
      if (done_o && busy_o) quiet_viol++;
      if (busy_o && prev_busy && (done_o || fail_o != prev_fail || speed_o != prev_speed))
        quiet_viol++;
      prev_train = train_en_o; prev_busy = busy_o; prev_fail = fail_o; prev_speed = speed_o;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic g2, input logic wd, input int a1, input int a2, input int ac,
                     input logic [3:0] s1, input logic [3:0] s2, input bit poke);
    @(negedge clk);
    allow_gen2_i = g2; wait_dsc_i = wd; d1 = a1; d2 = a2; dclr = ac; sp1 = s1; sp2 = s2;
    dsc_pulses = 0; done_pulses = 0; ovrd_cycles = 0; bad_ovrd = 0; quiet_viol = 0;
    max_at_train = 4'hF; max_at_dsc = 4'hF; ovrd_first = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    for (int i = 0; i < 3000 && done_pulses == 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11", "busy", busy_o, 0);
    chk("R11", "done", done_o, 0);
    chk("R11", "fail", fail_o, 0);
    chk("R11", "train_en", train_en_o, 0);
    chk("R11", "max_speed", max_speed_o, 1);
    chk("R11", "ovrd", phy_rx_ovrd_o, 0);
    chk("R11", "speed", speed_o, 0);
  endtask

  task automatic t_gen1_only;
    run(0, 1, 5, 0, 0, 4'd1, 4'd0, 0);
    chk("R1", "max at train rise", max_at_train, 1);
    chk("R2", "no kick when gen2 barred", dsc_pulses, 0);
    chk("R8", "gen1 fail", fail_o, 0);
    chk("R8", "gen1 speed", speed_o, 1);
    chk("R9", "done pulses", done_pulses, 1);
  endtask

  task automatic t_gen2_wait;
    run(1, 1, 6, 8, 4, 4'd1, 4'd2, 1);
    chk("R1", "max at train rise gen2", max_at_train, 1);
    chk("R2", "max at kick", max_at_dsc, 2);
    chk("R10", "one kick despite restart", dsc_pulses, 1);
    chk("R10", "one done despite restart", done_pulses, 1);
    chk("R10", "idle after run", busy_o, 0);
    chk("R3", "gen2 fail", fail_o, 0);
    chk("R5", "speed after retrain", speed_o, 2);
    chk("R9", "quiet while busy", quiet_viol, 0);
  endtask

  task automatic t_gen2_skip;
    run(1, 0, 4, 6, 0, 4'd1, 4'd1, 0);
    chk("R4", "stuck bit skipped fail", fail_o, 0);
    chk("R4", "stuck bit skipped speed", speed_o, 1);
    chk("R4", "done", done_pulses, 1);
  endtask

  task automatic t_gen2_stuck;
    run(1, 1, 4, 6, 0, 4'd1, 4'd1, 0);
    chk("R3", "stuck bit fail", fail_o, 1);
    chk("R3", "timeout distance", ovrd_first - kick_cyc, DSC_TMO + 1);
    chk("R7", "hold cycles", ovrd_cycles, PHY_HOLD);
    chk("R7", "bad override", bad_ovrd, 0);
    chk("R7", "speed zero", speed_o, 0);
    chk("R9", "quiet while busy", quiet_viol, 0);
  endtask

  task automatic t_second_link_missing;
    run(1, 0, 4, 0, 0, 4'd1, 4'd2, 0);
    chk("R5", "no second link-up fail", fail_o, 1);
    chk("R7", "hold cycles", ovrd_cycles, PHY_HOLD);
  endtask

  task automatic t_window_edges;
    run(0, 0, LINK_TMO, 0, 0, 4'd3, 4'd0, 0);
    chk("R6", "last admitted cycle fail", fail_o, 0);
    chk("R6", "last admitted cycle speed", speed_o, 3);
    run(0, 0, LINK_TMO + 1, 0, 0, 4'd3, 4'd0, 0);
    chk("R6", "one late fail", fail_o, 1);
    chk("R6", "timeout distance", ovrd_first - train_cyc, LINK_TMO);
    chk("R7", "hold cycles", ovrd_cycles, PHY_HOLD);
    chk("R7", "done after hold", done_pulses, 1);
  endtask

  task automatic t_rerun;
    run(0, 0, 0, 0, 0, 4'd1, 4'd0, 0);
    chk("R7", "never up fail", fail_o, 1);
    run(0, 0, 3, 0, 0, 4'd1, 4'd0, 0);
    chk("R8", "rerun fail cleared", fail_o, 0);
    chk("R8", "rerun speed", speed_o, 1);
    chk("R1", "max at train rise rerun", max_at_train, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    d1 = 0; d2 = 0; dclr = 0; sp1 = 0; sp2 = 0; cyc = 0;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_gen1_only;
    t_gen2_wait;
    t_gen2_skip;
    t_gen2_stuck;
    t_second_link_missing;
    t_window_edges;
    t_rerun;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule